// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block lets a synchronous host read a 16-bit successive-approximation converter over its three-wire serial port. It runs on a fast system clock and makes the converter's serial clock by toggling it every few system cycles. The number of cycles per phase comes from a divider setting and is never allowed below a safe floor. A trigger pulse lowers the active-low select line with the serial clock low. The controller then lets the converter's acquisition window pass and checks the single zero bit that precedes the data. After that it gathers the result, most significant bit first, on rising serial-clock edges. The finished word is offered on a valid/ready output port.

A frame can be cut short after a chosen number of bits to save converter power. The partial word then comes back left-aligned. With a full-length frame, an optional check mode keeps the clock running through the converter's reversed replay of the word. It reports whether the replay agrees with the forward copy. If the zero bit before the data reads high, a sticky framing flag is set. The select line always rests high for at least one full serial-clock period before a new frame can begin.

Top module: `sar_rdr_top`

## Requirements
- R1: After reset the select line is high, the serial clock is low, no result is valid and the framing flag is clear.
- R2: A trigger seen while idle with no result waiting drops the select line while the serial clock is low. The serial clock is low whenever the select line is high.
- R3: Every high and low phase of the serial clock inside a frame lasts exactly H system clocks. H is the divider setting, raised to MIN_HALF when the setting is smaller, and it is latched when the frame starts.
- R4: Rising serial-clock edges 1 to 5 are ignored and edge 6 reads the zero bit. Edges 7 to 22 read the 16-bit straight-binary result, most significant bit first, so edge 7 gives bit 15.
- R5: A high level read at edge 6 sets the framing flag. The flag stays set until reset, and the data bits of that frame are captured normally.
- R6: With a bit count n from 1 to 15, the frame has exactly 6+n rising edges before the select line rises. The result holds the n received bits in its top positions, and the remaining low bits are zero. A count of 0 or above 16 means 16.
- R7: With check mode on and n equal to 16, the frame runs 37 rising edges. Edges 23 to 37 read bits 1 up to 15 of the replay. The mismatch output is 1 exactly when any of these differs from the forward bit of the same weight. Without check mode, or with n below 16, there is no replay and mismatch is 0.
- R8: Each frame yields one result. While valid is high and ready is low, valid, data and mismatch hold steady.
- R9: Between the end of one frame and the start of the next, the select line stays high for at least 2*H system clocks.
- R10: A trigger that arrives during a frame, during the rest gap, or while a result waits unaccepted starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion trigger |
| cfg_half_i | input | DIV_W | Serial clock half period in system clocks |
| cfg_nbits_i | input | 5 | Bits to receive before ending the frame (0 means 16) |
| cfg_check_i | input | 1 | Enable replay cross-check on full frames |
| adc_csn_o | output | 1 | Active-low converter select |
| adc_sclk_o | output | 1 | Serial data clock to the converter |
| adc_sdo_i | input | 1 | Serial data from the converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Host accepts the result |
| res_data_o | output | 16 | Conversion result, left-aligned |
| res_mismatch_o | output | 1 | Replay disagreed with forward word |
| frame_err_o | output | 1 | Sticky flag: zero bit read high |

## Verification
The bench builds the block with MIN_HALF set to 3 and a 12-bit divider. At that floor, divider settings of 0 and 1 are visibly clamped, while settings of 4 and 5 pass through unchanged, and every phase length can be counted exactly. The short floor also keeps 37-edge check-mode frames brief, so full, shortened, over-range and replay frames all fit in one run. A behavioural converter model in the bench drives the zero bit and can flip one replay bit, and the bench fits both faults into that run as well.

// File: rtl/sar_rdr_pkg.sv
package sar_rdr_pkg;

    localparam int RES_W           = 16;
    localparam int SAMPLE_EDGES    = 5;
    localparam int NULL_EDGE       = SAMPLE_EDGES + 1;
    localparam int FIRST_DATA_EDGE = NULL_EDGE + 1;
    localparam int REPLAY_W        = RES_W - 1;
    localparam int MAX_EDGE        = NULL_EDGE + RES_W + REPLAY_W;
    localparam int EDGE_W          = $clog2(MAX_EDGE + 1);
    localparam int NB_W            = $clog2(RES_W + 1);
    localparam int IDX_W           = $clog2(RES_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [NB_W-1:0] nbits;
        logic            check;
    } frame_cfg_t;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic             mismatch;
    } result_t;

    // Out-of-range bit counts select a full-length frame.
    function automatic logic [NB_W-1:0] norm_nbits(input logic [NB_W-1:0] n);
        if (n == '0 || n > NB_W'(RES_W))
            return NB_W'(RES_W);
        return n;
    endfunction

    // Index of the final rising edge of a frame.
    function automatic logic [EDGE_W-1:0] last_edge(input frame_cfg_t c);
        logic [EDGE_W-1:0] e;
        e = EDGE_W'(NULL_EDGE) + EDGE_W'(c.nbits);
        if (c.check && c.nbits == NB_W'(RES_W))
            e = e + EDGE_W'(REPLAY_W);
        return e;
    endfunction

endpackage

// File: rtl/sar_rdr_tick.sv
module sar_rdr_tick #(
    parameter int DIV_W    = 12,
    parameter int MIN_HALF = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF);

    logic [DIV_W-1:0] half_eff;
    logic [DIV_W-1:0] cnt;

    assign half_eff = (half_i < FLOOR) ? FLOOR : half_i;
    assign tick_o   = en_i && (cnt == half_eff - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en_i)
            cnt <= '0;
        else if (tick_o)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/sar_rdr_seq.sv
module sar_rdr_seq
    import sar_rdr_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              hold_i,
    input  logic [DIV_W-1:0]  cfg_half_i,
    input  logic [NB_W-1:0]   cfg_nbits_i,
    input  logic              cfg_check_i,
    input  logic              tick_i,
    output logic              csn_o,
    output logic              sclk_o,
    output logic              run_o,
    output logic [DIV_W-1:0]  half_o,
    output logic              rise_o,
    output logic [EDGE_W-1:0] edge_o,
    output logic              start_o,
    output logic              done_o
);
    seq_state_e        state;
    frame_cfg_t        fcfg;
    logic              gap_second;
    logic [EDGE_W-1:0] edge_last;

    assign edge_last = last_edge(fcfg);
    assign run_o     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            csn_o      <= 1'b1;
            sclk_o     <= 1'b0;
            edge_o     <= '0;
            half_o     <= '0;
            fcfg       <= '0;
            gap_second <= 1'b0;
            rise_o     <= 1'b0;
            start_o    <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            rise_o  <= 1'b0;
            start_o <= 1'b0;
            done_o  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i && !hold_i) begin
                        csn_o      <= 1'b0;
                        sclk_o     <= 1'b0;
                        edge_o     <= '0;
                        half_o     <= cfg_half_i;
                        fcfg.nbits <= norm_nbits(cfg_nbits_i);
                        fcfg.check <= cfg_check_i;
                        start_o    <= 1'b1;
                        state      <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tick_i) begin
                        if (!sclk_o) begin
                            sclk_o <= 1'b1;
                            edge_o <= edge_o + EDGE_W'(1);
                            rise_o <= 1'b1;
                        end else begin
                            sclk_o <= 1'b0;
                            if (edge_o == edge_last) begin
                                csn_o      <= 1'b1;
                                done_o     <= 1'b1;
                                gap_second <= 1'b0;
                                state      <= ST_GAP;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick_i) begin
                        if (gap_second)
                            state <= ST_IDLE;
                        else
                            gap_second <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_rdr_capture.sv
module sar_rdr_capture
    import sar_rdr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdo_i,
    input  logic              frame_start_i,
    input  logic              rise_i,
    input  logic [EDGE_W-1:0] edge_i,
    input  logic              frame_done_i,
    input  logic              ready_i,
    output logic              valid_o,
    output result_t           result_o,
    output logic              frame_err_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sdo_s;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sdo_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sync_q[i-1];
            end
        end
    end
    assign sdo_s = sync_q[SYNC_STAGES-1];

    int               e;
    logic             at_null;
    logic             in_data;
    logic             in_replay;
    logic [IDX_W-1:0] dbit;
    logic [IDX_W-1:0] rbit;

    always_comb begin
        e         = int'(edge_i);
        at_null   = (e == NULL_EDGE);
        in_data   = (e >= FIRST_DATA_EDGE) && (e < FIRST_DATA_EDGE + RES_W);
        in_replay = (e >= FIRST_DATA_EDGE + RES_W);
        dbit      = IDX_W'(RES_W - 1 - (e - FIRST_DATA_EDGE));
        rbit      = IDX_W'(e - (FIRST_DATA_EDGE + RES_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o     <= 1'b0;
            result_o    <= '0;
            frame_err_o <= 1'b0;
        end else begin
            if (frame_start_i) begin
                result_o <= '0;
            end else if (rise_i) begin
                if (at_null) begin
                    if (sdo_s) frame_err_o <= 1'b1;
                end else if (in_data) begin
                    result_o.data[dbit] <= sdo_s;
                end else if (in_replay) begin
                    if (sdo_s != result_o.data[rbit]) result_o.mismatch <= 1'b1;
                end
            end
            if (frame_done_i)
                valid_o <= 1'b1;
            else if (valid_o && ready_i)
                valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_rdr_top.sv
module sar_rdr_top
    import sar_rdr_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int MIN_HALF    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DIV_W-1:0] cfg_half_i,
    input  logic [NB_W-1:0]  cfg_nbits_i,
    input  logic             cfg_check_i,
    output logic             adc_csn_o,
    output logic             adc_sclk_o,
    input  logic             adc_sdo_i,
    output logic             res_valid_o,
    input  logic             res_ready_i,
    output logic [RES_W-1:0] res_data_o,
    output logic             res_mismatch_o,
    output logic             frame_err_o
);
    logic              run;
    logic              tick;
    logic [DIV_W-1:0]  half_q;
    logic              rise;
    logic [EDGE_W-1:0] edge_idx;
    logic              frame_start;
    logic              frame_done;
    result_t           result;

    sar_rdr_tick #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .en_i   (run),
        .half_i (half_q),
        .tick_o (tick)
    );

    sar_rdr_seq #(
        .DIV_W (DIV_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .hold_i      (res_valid_o),
        .cfg_half_i  (cfg_half_i),
        .cfg_nbits_i (cfg_nbits_i),
        .cfg_check_i (cfg_check_i),
        .tick_i      (tick),
        .csn_o       (adc_csn_o),
        .sclk_o      (adc_sclk_o),
        .run_o       (run),
        .half_o      (half_q),
        .rise_o      (rise),
        .edge_o      (edge_idx),
        .start_o     (frame_start),
        .done_o      (frame_done)
    );

    sar_rdr_capture #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cap (
        .clk           (clk),
        .rst           (rst),
        .sdo_i         (adc_sdo_i),
        .frame_start_i (frame_start),
        .rise_i        (rise),
        .edge_i        (edge_idx),
        .frame_done_i  (frame_done),
        .ready_i       (res_ready_i),
        .valid_o       (res_valid_o),
        .result_o      (result),
        .frame_err_o   (frame_err_o)
    );

    assign res_data_o     = result.data;
    assign res_mismatch_o = result.mismatch;
endmodule

// File: rtl/sar_rdr_chk.sv
module sar_rdr_chk #(
    parameter int MIN_HALF = 20,
    parameter int RES_W    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             adc_csn_o,
    input logic             adc_sclk_o,
    input logic             res_valid_o,
    input logic             res_ready_i,
    input logic [RES_W-1:0] res_data_o,
    input logic             res_mismatch_o,
    input logic             frame_err_o
);
    logic        sclk_q;
    logic [15:0] phase_len;
    logic [15:0] high_len;
    logic        seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= 1'b0;
            phase_len  <= '0;
            high_len   <= '0;
            seen_frame <= 1'b0;
        end else begin
            sclk_q     <= adc_sclk_o;
            seen_frame <= seen_frame | !adc_csn_o;
            if (adc_sclk_o != sclk_q)
                phase_len <= 16'd1;
            else if (phase_len != 16'hFFFF)
                phase_len <= phase_len + 16'd1;
            if (!adc_csn_o)
                high_len <= '0;
            else if (high_len != 16'hFFFF)
                high_len <= high_len + 16'd1;
        end
    end

    assert_sclk_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        adc_csn_o |-> !adc_sclk_o);

    assert_sclk_phase_R3: assert property (@(posedge clk) disable iff (rst)
        (!adc_csn_o && adc_sclk_o != sclk_q) |-> (int'(phase_len) >= MIN_HALF));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> frame_err_o);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !res_ready_i) |=>
            (res_valid_o && $stable(res_data_o) && $stable(res_mismatch_o)));

    assert_cs_gap_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(adc_csn_o) && seen_frame) |-> (int'(high_len) >= 2 * MIN_HALF));

    assert_no_start_pending_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_csn_o) |-> !res_valid_o);
endmodule

bind sar_rdr_top sar_rdr_chk #(
    .MIN_HALF (MIN_HALF),
    .RES_W    (sar_rdr_pkg::RES_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .adc_csn_o      (adc_csn_o),
    .adc_sclk_o     (adc_sclk_o),
    .res_valid_o    (res_valid_o),
    .res_ready_i    (res_ready_i),
    .res_data_o     (res_data_o),
    .res_mismatch_o (res_mismatch_o),
    .frame_err_o    (frame_err_o)
);

// File: tb/sar_rdr_top_tb.sv
module sar_rdr_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 12;
    localparam int MIN_HALF   = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [DIV_W-1:0] cfg_half = '0;
    logic [4:0]       cfg_nbits = '0;
    logic             cfg_check = 1'b0;
    logic             csn;
    logic             sclk;
    logic             sdo = 1'b0;
    logic             valid;
    logic             ready = 1'b0;
    logic [15:0]      data;
    logic             mism;
    logic             ferr;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_rdr_top #(
        .DIV_W       (DIV_W),
        .MIN_HALF    (MIN_HALF),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start),
        .cfg_half_i     (cfg_half),
        .cfg_nbits_i    (cfg_nbits),
        .cfg_check_i    (cfg_check),
        .adc_csn_o      (csn),
        .adc_sclk_o     (sclk),
        .adc_sdo_i      (sdo),
        .res_valid_o    (valid),
        .res_ready_i    (ready),
        .res_data_o     (data),
        .res_mismatch_o (mism),
        .frame_err_o    (ferr)
    );

    // Converter model: bits change on falling serial clock edges.
    logic [15:0] m_word = '0;
    logic        m_null = 1'b0;
    int          m_corrupt = -1;
    int          fcnt = 0;
    int          rises = 0;
    int          csn_falls = 0;
    bit          m_active = 0;
    logic        m_sclk_prev = 1'b0;

    always @(csn, sclk) begin
        if (csn !== 1'b0) begin
            m_active = 0;
        end else if (!m_active) begin
            m_active = 1;
            fcnt = 0;
            sdo = 1'b0;
            csn_falls++;
        end else if (sclk === 1'b0 && m_sclk_prev === 1'b1) begin
            fcnt++;
            if (fcnt < 5)        sdo = 1'b0;
            else if (fcnt == 5)  sdo = m_null;
            else if (fcnt <= 21) sdo = m_word[21-fcnt];
            else if (fcnt <= 36) sdo = m_word[fcnt-21] ^ ((fcnt - 21) == m_corrupt);
            else                 sdo = 1'b0;
        end else if (sclk === 1'b1 && m_sclk_prev === 1'b0) begin
            rises++;
        end
        m_sclk_prev = sclk;
    end

    // Phase and gap monitor, sampled on the falling system clock edge.
    int   run_len = 0;
    bit   run_ok = 0;
    int   ph_min = 1000000;
    int   ph_max = 0;
    int   hi_len = 0;
    int   last_gap = 0;
    logic prev_sclk = 1'b0;
    logic prev_csn = 1'b1;

    always @(negedge clk) begin
        if (csn === 1'b0 && prev_csn === 1'b1) begin
            run_len = 1;
            run_ok = 1;
        end else if (sclk !== prev_sclk) begin
            if (run_ok) begin
                if (run_len < ph_min) ph_min = run_len;
                if (run_len > ph_max) ph_max = run_len;
            end
            run_len = 1;
            run_ok = (csn === 1'b0);
        end else begin
            run_len++;
        end
        if (csn === 1'b1) begin
            run_ok = 0;
            hi_len++;
        end else begin
            if (prev_csn === 1'b1) last_gap = hi_len;
            hi_len = 0;
        end
        prev_sclk = sclk;
        prev_csn = csn;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Starts a frame and waits for its result (left pending).
    task automatic run_frame(input logic [15:0] word, input int half, input int nbits,
                             input bit chk_mode, input bit null_hi, input int corrupt);
        m_word = word;
        m_null = null_hi;
        m_corrupt = corrupt;
        cfg_half = DIV_W'(half);
        cfg_nbits = 5'(nbits);
        cfg_check = chk_mode;
        rises = 0;
        ph_min = 1000000;
        ph_max = 0;
        @(negedge clk);
        start = 1'b1;
        while (csn !== 1'b0) @(negedge clk);
        start = 1'b0;
        chk(sclk === 1'b0, "R2", "sclk at select fall", 32'(sclk), 0);
        while (valid !== 1'b1) @(negedge clk);
    endtask

    task automatic accept();
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(csn === 1'b1, "R1", "csn after reset", 32'(csn), 1);
        chk(sclk === 1'b0, "R1", "sclk after reset", 32'(sclk), 0);
        chk(valid === 1'b0, "R1", "valid after reset", 32'(valid), 0);
        chk(ferr === 1'b0, "R1", "frame_err after reset", 32'(ferr), 0);
    endtask

    task automatic t_full(input logic [15:0] word, input int half);
        run_frame(word, half, 16, 0, 0, -1);
        chk(data === word, "R4", "full word", 32'(data), 32'(word));
        chk(rises == 22, "R4", "edge count", rises, 22);
        chk(mism === 1'b0, "R7", "mismatch off", 32'(mism), 0);
        chk(ferr === 1'b0, "R5", "no framing error", 32'(ferr), 0);
        chk(ph_min == half && ph_max == half, "R3", "phase length",
            32'(ph_min * 1000 + ph_max), 32'(half * 1000 + half));
        accept();
        chk(valid === 1'b0, "R8", "valid cleared by ready", 32'(valid), 0);
    endtask

    task automatic t_clamp(input int setting);
        run_frame(16'h3C5A, setting, 16, 0, 0, -1);
        chk(ph_min == MIN_HALF && ph_max == MIN_HALF, "R3", "clamped phase",
            32'(ph_min * 1000 + ph_max), 32'(MIN_HALF * 1000 + MIN_HALF));
        chk(data === 16'h3C5A, "R4", "data at clamped rate", 32'(data), 32'h3C5A);
        accept();
    endtask

    task automatic t_short(input logic [15:0] word, input int n);
        int eff;
        logic [15:0] exp;
        eff = (n == 0 || n > 16) ? 16 : n;
        exp = word & (16'hFFFF << (16 - eff));
        run_frame(word, 4, n, 0, 0, -1);
        chk(rises == 6 + eff, "R6", "short edge count", rises, 6 + eff);
        chk(data === exp, "R6", "left-aligned partial", 32'(data), 32'(exp));
        chk(csn === 1'b1, "R6", "select high after short frame", 32'(csn), 1);
        accept();
    endtask

    task automatic t_check(input logic [15:0] word, input int n, input int corrupt,
                           input bit exp_mm);
        int eff;
        eff = (n == 16) ? 37 : 6 + n;
        run_frame(word, 3, n, 1, 0, corrupt);
        chk(rises == eff, "R7", "check-mode edge count", rises, eff);
        chk(mism === exp_mm, "R7", "replay mismatch", 32'(mism), 32'(exp_mm));
        if (n == 16)
            chk(data === word, "R7", "word with replay", 32'(data), 32'(word));
        accept();
    endtask

    task automatic t_null();
        run_frame(16'h1234, 3, 16, 0, 1, -1);
        chk(ferr === 1'b1, "R5", "null high sets flag", 32'(ferr), 1);
        chk(data === 16'h1234, "R5", "data despite flag", 32'(data), 32'h1234);
        accept();
        run_frame(16'h4321, 3, 16, 0, 0, -1);
        chk(ferr === 1'b1, "R5", "flag sticky", 32'(ferr), 1);
        accept();
        do_reset();
        chk(ferr === 1'b0, "R5", "flag cleared by reset", 32'(ferr), 0);
    endtask

    task automatic t_hold();
        int falls0;
        run_frame(16'hC001, 3, 16, 0, 0, -1);
        falls0 = csn_falls;
        repeat (20) @(negedge clk);
        start = 1'b1;
        repeat (10) @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(csn_falls == falls0 && csn === 1'b1, "R10", "no frame while result pending",
            csn_falls - falls0, 0);
        chk(valid === 1'b1, "R8", "valid held", 32'(valid), 1);
        chk(data === 16'hC001, "R8", "data held", 32'(data), 32'hC001);
        accept();
        chk(valid === 1'b0, "R8", "single result", 32'(valid), 0);
    endtask

    task automatic t_busy();
        int falls0;
        falls0 = csn_falls;
        m_word = 16'h7E81;
        m_null = 0;
        m_corrupt = -1;
        cfg_half = DIV_W'(4);
        cfg_nbits = 5'd16;
        cfg_check = 1'b0;
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (valid !== 1'b1) @(negedge clk);
        chk(data === 16'h7E81, "R10", "data unaffected by trigger", 32'(data), 32'h7E81);
        start = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        accept();
        repeat (60) @(negedge clk);
        chk(csn_falls - falls0 == 1, "R10", "one frame per trigger", csn_falls - falls0, 1);
    endtask

    task automatic t_gap();
        int falls0;
        falls0 = csn_falls;
        m_word = 16'h0F0F;
        m_null = 0;
        m_corrupt = -1;
        cfg_half = DIV_W'(5);
        cfg_nbits = 5'd4;
        cfg_check = 1'b0;
        ready = 1'b1;
        start = 1'b1;
        while (csn_falls - falls0 < 2) @(negedge clk);
        start = 1'b0;
        chk(last_gap >= 10, "R9", "select rest gap", last_gap, 10);
        while (csn !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
        ready = 1'b0;
        chk(valid === 1'b0, "R8", "second result taken", 32'(valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog timeout");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_full(16'hA5C3, 4);
        t_full(16'h0001, 3);
        t_full(16'hFFFF, 5);
        t_full(16'h0000, 3);
        t_clamp(1);
        t_clamp(0);
        t_short(16'hBEEF, 4);
        t_short(16'hFFFF, 1);
        t_short(16'h8001, 15);
        t_short(16'h9AB7, 3);
        t_short(16'h5A5A, 0);
        t_short(16'h6B6B, 20);
        t_check(16'hD24B, 16, -1, 0);
        t_check(16'hD24B, 16, 7, 1);
        t_check(16'h8000, 16, 15, 1);
        t_check(16'hD24B, 8, 3, 0);
        t_hold();
        t_busy();
        t_gap();
        t_null();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule